// File: doc/BRIEF.md
# Power Switch Startup Sequencer

This is a synchronous controller that brings a protected power switch up safely. It merges two enable inputs: a high-voltage enable that is active low and a logic-level enable that is active high. It watches four comparator flags: input below its under-voltage level, input above its over-voltage level, output above its under-voltage level, and output risen to within the drop threshold of the input. From these it decides when the pass switch may close.

After a qualifying input or enable event, the block waits out a debounce interval and then closes the switch. It then runs a two-stage startup. For a short first window it selects a raised current-limit multiplier. Inside a much longer timeout it waits for the output to come up. If the output reaches the input, the block emits a one-cycle done pulse. It then marks a window during which the reverse-current comparator should use its relaxed threshold. If the output does not come up before the timeout, the switch opens and a fault latch holds it open until the request is withdrawn or the input drops below its under-voltage level.

Every interval is a parameter counted in pulses of a tick input, so one design serves any tick period. Analog current regulation and thermal behaviour live outside this block.

Top module: `switch_startup_seq`

## Requirements
- R1: The switch is requested only when `hvEnN`=0 (whatever `lvEn` is) or when `hvEnN`=1 with `lvEn`=1. With `hvEnN`=1 and `lvEn`=0 the switch stays open.
- R2: With the request present, input not under-voltage, no over-voltage, and `outAboveUv`=0, the switch closes after `DEB_TICKS` tick pulses of debounce. It closes on the cycle after the clock edge that sees the last tick.
- R3: If the input goes under-voltage, or the request drops, during debounce, the switch stays open. The debounce count starts again from zero at the next qualifying condition.
- R4: If `outAboveUv`=1 when the conditions become valid, the debounce is skipped and the switch closes one clock after they are seen.
- R5: `limitSel` encodes the current-limit multiplier as 2'b00 = 1x, 2'b01 = 1.5x and 2'b10 = 2x. It equals parameter `BOOST_SEL` from switch closure until `BOOST_TICKS` ticks have passed while closed, and is 2'b00 at all other times.
- R6: If `outReached` is not seen within `TIMEOUT_TICKS` ticks of switch closure, the switch opens and `startFault` rises. Both hold, even if `outReached` later rises, until the request is withdrawn or `inUv` goes high.
- R7: `forceCont` is 1 exactly while the switch is closed and startup is still in progress, demanding continuous current limiting whatever fault mode is chosen elsewhere.
- R8: `startDone` is a one-cycle pulse, issued in the cycle after `outReached` is seen during startup.
- R9: `revRelaxed` is 1 from the end of startup until `RELAX_TICKS` ticks have passed in the running state, and 0 otherwise.
- R10: `inOv`=1 opens the switch on the next cycle. After it clears, the sequence restarts from the debounce decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base pulse, one clock wide |
| hvEnN | input | 1 | High-voltage enable, active low |
| lvEn | input | 1 | Logic-level enable, active high |
| inUv | input | 1 | Input below under-voltage level |
| inOv | input | 1 | Input above over-voltage level |
| outAboveUv | input | 1 | Output above its under-voltage level |
| outReached | input | 1 | Output within drop threshold of input |
| switchOn | output | 1 | Close the pass switch |
| limitSel | output | 2 | Current-limit multiplier code |
| forceCont | output | 1 | Force continuous limiting during startup |
| startDone | output | 1 | One-cycle startup-complete pulse |
| startFault | output | 1 | Startup timeout latched |
| revRelaxed | output | 1 | Use relaxed reverse-current threshold |

## Verification
The bench builds the block with a debounce of 5 ticks, a boost window of 8, a startup timeout of 30, a relaxed window of 6 and the 1.5x boost code. These values let a few thousand cycles cover every terminal count, including the timeout latch and its release. Because the boost window is shorter than the timeout but longer than the debounce, boost expiry, done-before-boost-end and timeout-after-boost all occur. Random tick density and random flips of the input flags push aborts into every state.

// File: rtl/swseq_pkg.sv
package swseq_pkg;
  localparam logic [1:0] LIM_1X   = 2'b00;
  localparam logic [1:0] LIM_1P5X = 2'b01;
  localparam logic [1:0] LIM_2X   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEB   = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_LATCH = 3'd4
  } seqState_t;

  typedef struct packed {
    logic phaseClr;
    logic phaseRun;
    logic onRun;
    logic relaxRun;
  } seqStrobe_t;
endpackage

// File: rtl/swseq_timers.sv
module swseq_timers
  import swseq_pkg::*;
#(
  parameter int DEB_TICKS     = 500,
  parameter int BOOST_TICKS   = 24000,
  parameter int TIMEOUT_TICKS = 1200000,
  parameter int RELAX_TICKS   = 16000,
  parameter logic [1:0] BOOST_SEL = LIM_2X
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  seqStrobe_t strobe,
  output logic       debLast,
  output logic       toLast,
  output logic [1:0] limitSel,
  output logic       revRelaxed
);
  localparam int PH_MAX = (DEB_TICKS > TIMEOUT_TICKS) ? DEB_TICKS : TIMEOUT_TICKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int ON_W   = $clog2(BOOST_TICKS + 1);
  localparam int RL_W   = $clog2(RELAX_TICKS + 1);

  logic [PH_W-1:0] phaseCnt;
  logic [ON_W-1:0] onCnt;
  logic [RL_W-1:0] relaxCnt;
  logic            boostActive;

  // shared counter for debounce and startup timeout; cleared on every state change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        phaseCnt <= '0;
    else if (strobe.phaseClr)         phaseCnt <= '0;
    else if (strobe.phaseRun && tick) phaseCnt <= phaseCnt + 1'b1;
  end

  // time since switch closure, saturating at the boost window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             onCnt <= '0;
    else if (!strobe.onRun) onCnt <= '0;
    else if (tick && (onCnt < ON_W'(BOOST_TICKS))) onCnt <= onCnt + 1'b1;
  end

  // time since startup completed, saturating at the relaxed window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                relaxCnt <= '0;
    else if (!strobe.relaxRun) relaxCnt <= '0;
    else if (tick && (relaxCnt < RL_W'(RELAX_TICKS))) relaxCnt <= relaxCnt + 1'b1;
  end

  assign debLast     = tick && (phaseCnt == PH_W'(DEB_TICKS - 1));
  assign toLast      = tick && (phaseCnt == PH_W'(TIMEOUT_TICKS - 1));
  assign boostActive = strobe.onRun && (onCnt < ON_W'(BOOST_TICKS));
  assign limitSel    = boostActive ? BOOST_SEL : LIM_1X;
  assign revRelaxed  = strobe.relaxRun && (relaxCnt < RL_W'(RELAX_TICKS));

  AST_NO_BOOST_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.onRun |-> (limitSel == LIM_1X)); // R5
endmodule

// File: rtl/swseq_ctrl.sv
module swseq_ctrl
  import swseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hvEnN,
  input  logic       lvEn,
  input  logic       inUv,
  input  logic       inOv,
  input  logic       outAboveUv,
  input  logic       outReached,
  input  logic       debLast,
  input  logic       toLast,
  output seqStrobe_t strobe,
  output logic       switchOn,
  output logic       forceCont,
  output logic       startDone,
  output logic       startFault
);
  seqState_t state, nextState;
  logic      request;
  logic      okNow;

  assign request = !hvEnN || lvEn;
  assign okNow   = request && !inUv && !inOv;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (okNow) nextState = outAboveUv ? ST_RAMP : ST_DEB;
      ST_DEB:   if (!okNow) nextState = ST_IDLE;
                else if (debLast) nextState = ST_RAMP;
      ST_RAMP:  if (!okNow) nextState = ST_IDLE;
                else if (outReached) nextState = ST_RUN;
                else if (toLast) nextState = ST_LATCH;
      ST_RUN:   if (!okNow) nextState = ST_IDLE;
      ST_LATCH: if (!request || inUv) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startDone <= 1'b0;
    end else begin
      state     <= nextState;
      startDone <= (state == ST_RAMP) && (nextState == ST_RUN);
    end
  end

  assign strobe.phaseClr = (nextState != state);
  assign strobe.phaseRun = (state == ST_DEB) || (state == ST_RAMP);
  assign strobe.onRun    = (state == ST_RAMP) || (state == ST_RUN);
  assign strobe.relaxRun = (state == ST_RUN);

  assign switchOn   = strobe.onRun;
  assign forceCont  = (state == ST_RAMP);
  assign startFault = (state == ST_LATCH);

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (hvEnN && !lvEn) |=> !switchOn); // R1
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    inUv |=> !switchOn); // R3
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (startFault && request && !inUv) |=> startFault); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    startDone |=> !startDone); // R8
  AST_OV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    inOv |=> !switchOn); // R10
endmodule

// File: rtl/switch_startup_seq.sv
module switch_startup_seq
  import swseq_pkg::*;
#(
  parameter int DEB_TICKS     = 500,
  parameter int BOOST_TICKS   = 24000,
  parameter int TIMEOUT_TICKS = 1200000,
  parameter int RELAX_TICKS   = 16000,
  parameter logic [1:0] BOOST_SEL = LIM_2X
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       hvEnN,
  input  logic       lvEn,
  input  logic       inUv,
  input  logic       inOv,
  input  logic       outAboveUv,
  input  logic       outReached,
  output logic       switchOn,
  output logic [1:0] limitSel,
  output logic       forceCont,
  output logic       startDone,
  output logic       startFault,
  output logic       revRelaxed
);
  seqStrobe_t strobe;
  logic       debLast;
  logic       toLast;

  swseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hvEnN(hvEnN), .lvEn(lvEn), .inUv(inUv), .inOv(inOv),
    .outAboveUv(outAboveUv), .outReached(outReached), .debLast(debLast), .toLast(toLast),
    .strobe(strobe), .switchOn(switchOn), .forceCont(forceCont),
    .startDone(startDone), .startFault(startFault)
  );

  swseq_timers #(
    .DEB_TICKS(DEB_TICKS), .BOOST_TICKS(BOOST_TICKS), .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .RELAX_TICKS(RELAX_TICKS), .BOOST_SEL(BOOST_SEL)
  ) uTimers (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe), .debLast(debLast),
    .toLast(toLast), .limitSel(limitSel), .revRelaxed(revRelaxed)
  );
endmodule

// File: tb/sim_switch_startup_seq.sv
`timescale 1ns/1ps
module sim_switch_startup_seq;
  localparam int DEB = 5, BOOST = 8, TMO = 30, RELAX = 6;
  localparam logic [1:0] BSEL = 2'b01;
  localparam int M_IDLE = 0, M_DEB = 1, M_RAMP = 2, M_RUN = 3, M_LATCH = 4;

  logic clk = 0, rstN = 0, tick = 0;
  logic hvEnN = 1, lvEn = 0, inUv = 0, inOv = 0, outAboveUv = 0, outReached = 0;
  logic switchOn, forceCont, startDone, startFault, revRelaxed;
  logic [1:0] limitSel;

  int nChk = 0, nFail = 0, tickPct = 100;
  bit cmpOn = 0, ended = 0;
  int mSt = M_IDLE, mPh = 0, mOn = 0, mRl = 0;
  bit mDone = 0;

  always #2 clk = ~clk;

  switch_startup_seq #(.DEB_TICKS(DEB), .BOOST_TICKS(BOOST), .TIMEOUT_TICKS(TMO),
    .RELAX_TICKS(RELAX), .BOOST_SEL(BSEL)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .hvEnN(hvEnN), .lvEn(lvEn), .inUv(inUv),
    .inOv(inOv), .outAboveUv(outAboveUv), .outReached(outReached), .switchOn(switchOn),
    .limitSel(limitSel), .forceCont(forceCont), .startDone(startDone),
    .startFault(startFault), .revRelaxed(revRelaxed));

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // next sequencer state from the requirement text
  function automatic int nextOf(int st, int ph, bit tk);
    bit req = !hvEnN || lvEn;
    bit ok  = req && !inUv && !inOv;
    case (st)
      M_IDLE:  return ok ? (outAboveUv ? M_RAMP : M_DEB) : M_IDLE;
      M_DEB:   return !ok ? M_IDLE : ((tk && ph == DEB - 1) ? M_RAMP : M_DEB);
      M_RAMP:  return !ok ? M_IDLE : (outReached ? M_RUN : ((tk && ph == TMO - 1) ? M_LATCH : M_RAMP));
      M_RUN:   return ok ? M_RUN : M_IDLE;
      default: return (!req || inUv) ? M_IDLE : M_LATCH;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt <= M_IDLE; mPh <= 0; mOn <= 0; mRl <= 0; mDone <= 0;
    end else begin
      int nx;
      bit on;
      nx = nextOf(mSt, mPh, tick);
      on = (mSt == M_RAMP) || (mSt == M_RUN);
      mSt <= nx;
      mPh <= (nx != mSt) ? 0 : (((mSt == M_DEB || mSt == M_RAMP) && tick) ? mPh + 1 : mPh);
      mOn <= !on ? 0 : ((tick && mOn < BOOST) ? mOn + 1 : mOn);
      mRl <= (mSt != M_RUN) ? 0 : ((tick && mRl < RELAX) ? mRl + 1 : mRl);
      mDone <= (mSt == M_RAMP) && (nx == M_RUN);
    end
  end

  always @(negedge clk) begin
    tick <= ($urandom_range(99) < tickPct);
    if (cmpOn) begin
      bit on;
      on = (mSt == M_RAMP) || (mSt == M_RUN);
      chk("R2 switchOn", int'(switchOn), int'(on));
      chk("R5 limitSel", int'(limitSel), (on && mOn < BOOST) ? int'(BSEL) : 0);
      chk("R7 forceCont", int'(forceCont), int'(mSt == M_RAMP));
      chk("R8 startDone", int'(startDone), int'(mDone));
      chk("R9 revRelaxed", int'(revRelaxed), int'(mSt == M_RUN && mRl < RELAX));
      chk("R6 startFault", int'(startFault), int'(mSt == M_LATCH));
    end
  end

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  %0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    waitN(3);
    rstN = 1;
    chk("R2 reset switchOn", int'(switchOn), 0);
    chk("R6 reset startFault", int'(startFault), 0);
    chk("R5 reset limitSel", int'(limitSel), 0);
    cmpOn = 1;

    // R1: enable truth table
    hvEnN = 1; lvEn = 0; waitN(40);
    chk("R1 hv=1 lv=0 off", int'(switchOn), 0);
    hvEnN = 0; lvEn = 0; waitN(5);
    chk("R2 before debounce end", int'(switchOn), 0);
    waitN(1);
    chk("R2 after debounce end", int'(switchOn), 1);
    chk("R1 hv=0 lv=0 on", int'(switchOn), 1);
    chk("R5 boost code", int'(limitSel), int'(BSEL));
    chk("R7 startup active", int'(forceCont), 1);
    outReached = 1; waitN(1);
    chk("R8 done pulse", int'(startDone), 1);
    chk("R9 relaxed window", int'(revRelaxed), 1);
    waitN(1);
    chk("R8 pulse ends", int'(startDone), 0);
    hvEnN = 1; lvEn = 1; waitN(12);
    chk("R1 hv=1 lv=1 on", int'(switchOn), 1);
    chk("R5 back to 1x", int'(limitSel), 0);
    chk("R9 window over", int'(revRelaxed), 0);

    // R10: over-voltage opens at once
    inOv = 1; waitN(1);
    chk("R10 ov off", int'(switchOn), 0);
    inOv = 0; waitN(8);

    // R6: startup timeout latch
    lvEn = 0; outReached = 0; outAboveUv = 0; waitN(3);
    lvEn = 1; waitN(DEB + TMO + 6);
    chk("R6 latched", int'(startFault), 1);
    chk("R6 switch off", int'(switchOn), 0);
    outReached = 1; waitN(10);
    chk("R6 latch holds", int'(startFault), 1);
    lvEn = 0; waitN(2);
    chk("R6 latch cleared", int'(startFault), 0);

    // R4: debounce skipped
    outAboveUv = 1; outReached = 0; lvEn = 1; waitN(1);
    chk("R4 immediate on", int'(switchOn), 1);
    lvEn = 0; outAboveUv = 0; waitN(3);

    // R3: under-voltage during debounce restarts it
    lvEn = 1; waitN(3);
    inUv = 1; waitN(1);
    chk("R3 uv off", int'(switchOn), 0);
    inUv = 0; waitN(4);
    chk("R3 still debouncing", int'(switchOn), 0);
    waitN(2);
    chk("R3 on after full debounce", int'(switchOn), 1);

    // random phase
    tickPct = 50;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(99) < 3) hvEnN = ~hvEnN;
      if ($urandom_range(99) < 3) lvEn = ~lvEn;
      if ($urandom_range(199) < 2) inUv = ~inUv;
      if ($urandom_range(199) < 2) inOv = ~inOv;
      if ($urandom_range(99) < 4) outAboveUv = ~outAboveUv;
      if ($urandom_range(99) < 4) outReached = ~outReached;
      if (inOv && $urandom_range(9) < 5) inOv = 0;
    end
    waitN(2);
    finishRun();
  end
endmodule